// File: doc/BRIEF.md
# Self-Timed Flash Byte Programming Controller

This block controls programming of a small on-chip program memory. It writes single bytes, programs three protection (lock) bits and clears everything with a chip erase. It also serves verify reads and a fixed three-byte identity read. A 3-bit mode input selects the operation. An active-low strobe acts as the program pulse, and also as the erase strobe when it is held low. Every write times itself: the controller latches address and data on the rising edge of the strobe and drops `ready_o`. It commits the write after a fixed number of cycles and then raises `ready_o` again.

While a byte write is in progress, software can poll the written address at any time. It sees the complement of the written bit 7 until the write has finished, and then the true byte. Programming can only clear bits, so a byte that is not blank cannot be changed to new data without an erase. Once lock bit 1 or lock bit 2 is programmed, verify reads no longer return the array contents. Only a chip erase clears the lock bits. The array and the lock bits are held in behavioural storage that reset does not touch. All durations are parameters counted in clock cycles.

Top module: `flash_prog_ctrl`

## Requirements
- R1: In mode 3, holding `strobe_n_i` low for ERASE_CYCLES consecutive clock edges while ready sets every array byte to 0xFF and returns all three lock bits to unprogrammed. A shorter hold changes nothing.
- R2: In mode 1, a rising edge of `strobe_n_i` while ready latches `addr_i` and `wdata_i`. `ready_o` goes low at the next clock edge and stays low for exactly WRITE_CYCLES cycles. When `ready_o` rises, the new array contents are visible.
- R3: While `ready_o` is low after a mode 1 start, a mode 4 read of the latched address returns {~data[7], 7'b0}. Every other mode 4 read during a write returns 0xFF.
- R4: A byte write stores the AND of the old byte and the new data, so programming only ever clears bits.
- R5: In mode 2, a rising edge of `strobe_n_i` while ready starts a self-timed write of the same length as R2. `addr_i[1:0]` selects the lock bit: value 0 selects lock 1, value 1 selects lock 2, value 2 selects lock 3, and value 3 programs nothing.
- R6: When lock 1 or lock 2 is programmed, mode 4 reads return 0xFF. Lock 3 alone does not hide the contents.
- R7: In mode 5, address 0x30 reads 0x1E and 0x31 reads 0x51. Address 0x32 reads 0xFF when LOW_VOLT=0 and 0x05 when LOW_VOLT=1. Any other address reads 0xFF. The lock bits have no effect on mode 5.
- R8: A rising edge of `strobe_n_i` in mode 1 or 2 while `ready_o` is low is ignored: the array is unchanged and the write window is not extended. The edge sets `err_o`, which stays high until reset.
- R9: Reset sets `ready_o` to 1 and `err_o` to 0, and leaves the array and the lock bits unchanged.
- R10: Modes 0, 3, 6 and 7 read 0xFF. A rising edge of `strobe_n_i` in mode 4 or 5 starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | 0 idle, 1 byte program, 2 lock program, 3 erase, 4 verify, 5 identity read |
| addr_i | input | ADDR_W | Byte address; bits 1:0 select the lock bit in mode 2 |
| wdata_i | input | 8 | Byte to program |
| strobe_n_i | input | 1 | Active-low program pulse / erase strobe |
| ready_o | output | 1 | High when idle, low during a self-timed write |
| rdata_o | output | 8 | Read data, including status polling |
| err_o | output | 1 | Sticky flag for a strobe ignored while busy |

## Verification
The hardest situation to reach is a second program pulse that lands inside an ongoing write. The bench produces it by driving a full strobe low-high cycle two clock cycles after the first start. It then checks that `ready_o` still rises on the original schedule and that the second address is unchanged. Polling is observed within the same busy window, at the latched address and at a neighbour, for data with bit 7 both set and clear. The AND rule is covered by two full program passes over every address with different data patterns, each followed by a verify sweep. Lock behaviour is walked through each lock bit in turn, the unused selector included, with erases in between.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

    typedef enum logic [2:0] {
        MODE_IDLE      = 3'd0,
        MODE_PROG_BYTE = 3'd1,
        MODE_PROG_LOCK = 3'd2,
        MODE_ERASE     = 3'd3,
        MODE_VERIFY    = 3'd4,
        MODE_IDENT     = 3'd5,
        MODE_RSV6      = 3'd6,
        MODE_RSV7      = 3'd7
    } fp_mode_e;

    localparam int LOCK_BITS = 3;

    localparam logic [7:0] BLANK_BYTE  = 8'hFF;
    localparam logic [7:0] ID_MAKER    = 8'h1E;
    localparam logic [7:0] ID_DEVICE   = 8'h51;
    localparam logic [7:0] ID_VPP_HIGH = 8'hFF;
    localparam logic [7:0] ID_VPP_LOW  = 8'h05;

    localparam logic [7:0] ID_ADDR_MAKER  = 8'h30;
    localparam logic [7:0] ID_ADDR_DEVICE = 8'h31;
    localparam logic [7:0] ID_ADDR_VPP    = 8'h32;

    // Latched write request
    typedef struct packed {
        logic       is_lock;
        logic [1:0] lock_sel;
        logic [7:0] data;
    } wr_req_t;

    // Status byte seen while a byte write is still running
    function automatic logic [7:0] poll_byte(input logic [7:0] d);
        return {~d[7], 7'b0};
    endfunction

    // Lock 1 or lock 2 programmed (0 = programmed) hides the array
    function automatic logic read_blocked(input logic [LOCK_BITS-1:0] lk);
        return !lk[0] || !lk[1];
    endfunction

    function automatic logic is_prog_mode(input fp_mode_e m);
        return (m == MODE_PROG_BYTE) || (m == MODE_PROG_LOCK);
    endfunction

endpackage

// File: rtl/flash_strobe_ctl.sv
module flash_strobe_ctl
    import flash_prog_pkg::*;
#(
    parameter int ERASE_CYCLES = 1250000
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     strobe_n_i,
    input  fp_mode_e mode_i,
    input  logic     busy_i,
    output logic     start_o,
    output logic     erase_o
);

    localparam int EW = $clog2(ERASE_CYCLES + 1);
    localparam logic [EW-1:0] HOLD_MAX  = EW'(ERASE_CYCLES);
    localparam logic [EW-1:0] HOLD_LAST = EW'(ERASE_CYCLES - 1);

    logic          strobe_q;
    logic [EW-1:0] hold_cnt;
    logic          hold_low;

    always_ff @(posedge clk) begin
        if (rst) strobe_q <= 1'b1;
        else     strobe_q <= strobe_n_i;
    end

    assign start_o  = strobe_n_i && !strobe_q && is_prog_mode(mode_i);
    assign hold_low = (mode_i == MODE_ERASE) && !strobe_n_i && !busy_i;

    always_ff @(posedge clk) begin
        if (rst || !hold_low)       hold_cnt <= '0;
        else if (hold_cnt != HOLD_MAX) hold_cnt <= hold_cnt + 1'b1;
    end

    // Fires once, on the ERASE_CYCLES-th edge of a continuous low hold
    assign erase_o = hold_low && (hold_cnt == HOLD_LAST);

endmodule

// File: rtl/flash_write_timer.sv
module flash_write_timer
    import flash_prog_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int WRITE_CYCLES = 187500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  fp_mode_e          mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    output logic              busy_o,
    output logic              err_o,
    output logic              commit_o,
    output logic [ADDR_W-1:0] lat_addr_o,
    output wr_req_t           lat_req_o
);

    localparam int CW = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(WRITE_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o     <= 1'b0;
            err_o      <= 1'b0;
            cnt        <= '0;
            lat_addr_o <= '0;
            lat_req_o  <= '0;
        end else begin
            if (busy_o) begin
                if (cnt == CNT_LAST) busy_o <= 1'b0;
                else                 cnt    <= cnt + 1'b1;
            end
            if (start_i && busy_o) err_o <= 1'b1;
            if (start_i && !busy_o) begin
                busy_o             <= 1'b1;
                cnt                <= '0;
                lat_addr_o         <= addr_i;
                lat_req_o.is_lock  <= (mode_i == MODE_PROG_LOCK);
                lat_req_o.lock_sel <= addr_i[1:0];
                lat_req_o.data     <= wdata_i;
            end
        end
    end

    assign commit_o = busy_o && (cnt == CNT_LAST);

endmodule

// File: rtl/flash_array.sv
module flash_array
    import flash_prog_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 commit_i,
    input  logic                 erase_i,
    input  logic [ADDR_W-1:0]    lat_addr_i,
    input  wr_req_t              lat_req_i,
    input  logic [ADDR_W-1:0]    rd_addr_i,
    output logic [7:0]           rd_byte_o,
    output logic [LOCK_BITS-1:0] lock_o
);

    localparam int DEPTH = 1 << ADDR_W;

    // Non-volatile storage: no reset
    logic [7:0]           mem [DEPTH];
    logic [LOCK_BITS-1:0] lock_q;

    always_ff @(posedge clk) begin
        if (erase_i) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= BLANK_BYTE;
        end else if (commit_i && !lat_req_i.is_lock) begin
            mem[lat_addr_i] <= mem[lat_addr_i] & lat_req_i.data;
        end
    end

    always_ff @(posedge clk) begin
        if (erase_i) begin
            lock_q <= '1;
        end else if (commit_i && lat_req_i.is_lock) begin
            for (int k = 0; k < LOCK_BITS; k++)
                if (lat_req_i.lock_sel == 2'(k)) lock_q[k] <= 1'b0;
        end
    end

    assign rd_byte_o = mem[rd_addr_i];
    assign lock_o    = lock_q;

endmodule

// File: rtl/flash_read_mux.sv
module flash_read_mux
    import flash_prog_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int LOW_VOLT = 0
) (
    input  fp_mode_e             mode_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 busy_i,
    input  logic [ADDR_W-1:0]    lat_addr_i,
    input  logic                 lat_is_lock_i,
    input  logic [7:0]           lat_data_i,
    input  logic [7:0]           arr_byte_i,
    input  logic [LOCK_BITS-1:0] lock_i,
    output logic [7:0]           rdata_o
);

    localparam logic [ADDR_W-1:0] A_MAKER  = ADDR_W'(ID_ADDR_MAKER);
    localparam logic [ADDR_W-1:0] A_DEVICE = ADDR_W'(ID_ADDR_DEVICE);
    localparam logic [ADDR_W-1:0] A_VPP    = ADDR_W'(ID_ADDR_VPP);

    logic [7:0] id_vpp;

    generate
        if (LOW_VOLT != 0) begin : g_low_volt
            assign id_vpp = ID_VPP_LOW;
        end else begin : g_high_volt
            assign id_vpp = ID_VPP_HIGH;
        end
    endgenerate

    always_comb begin
        rdata_o = BLANK_BYTE;
        case (mode_i)
            MODE_VERIFY: begin
                if (busy_i) begin
                    if (!lat_is_lock_i && (addr_i == lat_addr_i))
                        rdata_o = poll_byte(lat_data_i);
                end else if (!read_blocked(lock_i)) begin
                    rdata_o = arr_byte_i;
                end
            end
            MODE_IDENT: begin
                if      (addr_i == A_MAKER)  rdata_o = ID_MAKER;
                else if (addr_i == A_DEVICE) rdata_o = ID_DEVICE;
                else if (addr_i == A_VPP)    rdata_o = id_vpp;
            end
            default: rdata_o = BLANK_BYTE;
        endcase
    end

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
    import flash_prog_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int WRITE_CYCLES = 187500,
    parameter int ERASE_CYCLES = 1250000,
    parameter int LOW_VOLT     = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    input  logic              strobe_n_i,
    output logic              ready_o,
    output logic [7:0]        rdata_o,
    output logic              err_o
);

    fp_mode_e             mode;
    logic                 start;
    logic                 erase;
    logic                 busy;
    logic                 commit;
    logic [ADDR_W-1:0]    lat_addr;
    wr_req_t              lat_req;
    logic [7:0]           arr_byte;
    logic [LOCK_BITS-1:0] lock;

    assign mode = fp_mode_e'(mode_i);

    flash_strobe_ctl #(.ERASE_CYCLES(ERASE_CYCLES)) u_strobe (
        .clk        (clk),
        .rst        (rst),
        .strobe_n_i (strobe_n_i),
        .mode_i     (mode),
        .busy_i     (busy),
        .start_o    (start),
        .erase_o    (erase)
    );

    flash_write_timer #(.ADDR_W(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .mode_i     (mode),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .busy_o     (busy),
        .err_o      (err_o),
        .commit_o   (commit),
        .lat_addr_o (lat_addr),
        .lat_req_o  (lat_req)
    );

    flash_array #(.ADDR_W(ADDR_W)) u_array (
        .clk        (clk),
        .commit_i   (commit),
        .erase_i    (erase),
        .lat_addr_i (lat_addr),
        .lat_req_i  (lat_req),
        .rd_addr_i  (addr_i),
        .rd_byte_o  (arr_byte),
        .lock_o     (lock)
    );

    flash_read_mux #(.ADDR_W(ADDR_W), .LOW_VOLT(LOW_VOLT)) u_rmux (
        .mode_i        (mode),
        .addr_i        (addr_i),
        .busy_i        (busy),
        .lat_addr_i    (lat_addr),
        .lat_is_lock_i (lat_req.is_lock),
        .lat_data_i    (lat_req.data),
        .arr_byte_i    (arr_byte),
        .lock_i        (lock),
        .rdata_o       (rdata_o)
    );

    assign ready_o = !busy;

endmodule

// File: rtl/flash_prog_chk.sv
module flash_prog_chk #(
    parameter int ADDR_W       = 8,
    parameter int WRITE_CYCLES = 187500
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        mode_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [7:0]        wdata_i,
    input logic              ready_o,
    input logic [7:0]        rdata_o,
    input logic              err_o,
    input logic              start_i,
    input logic [2:0]        lock_i
);

    logic [ADDR_W-1:0] sh_addr;
    logic [7:0]        sh_data;
    logic              sh_byte;
    int                busy_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_addr <= '0;
            sh_data <= '0;
            sh_byte <= 1'b0;
        end else if (start_i && ready_o) begin
            sh_addr <= addr_i;
            sh_data <= wdata_i;
            sh_byte <= (mode_i == 3'd1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ready_o) busy_len <= 0;
        else                busy_len <= busy_len + 1;
    end

    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        start_i && ready_o |=> !ready_o);

    p_busy_window_r2: assert property (@(posedge clk) disable iff (rst)
        !ready_o |-> busy_len < WRITE_CYCLES);

    p_poll_msb_r3: assert property (@(posedge clk) disable iff (rst)
        !ready_o && sh_byte && mode_i == 3'd4 && addr_i == sh_addr
        |-> rdata_o[7] == ~sh_data[7]);

    p_locked_blank_r6: assert property (@(posedge clk) disable iff (rst)
        ready_o && mode_i == 3'd4 && (!lock_i[0] || !lock_i[1])
        |-> rdata_o == 8'hFF);

    p_ident_maker_r7: assert property (@(posedge clk) disable iff (rst)
        mode_i == 3'd5 && addr_i == ADDR_W'(8'h30) |-> rdata_o == 8'h1E);

    p_busy_pulse_err_r8: assert property (@(posedge clk) disable iff (rst)
        start_i && !ready_o |=> err_o);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    p_reset_state_r9: assert property (@(posedge clk)
        rst |=> ready_o && !err_o);

endmodule

bind flash_prog_ctrl flash_prog_chk #(
    .ADDR_W       (ADDR_W),
    .WRITE_CYCLES (WRITE_CYCLES)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mode_i  (mode_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .ready_o (ready_o),
    .rdata_o (rdata_o),
    .err_o   (err_o),
    .start_i (start),
    .lock_i  (lock)
);

// File: tb/flash_prog_ctrl_test.sv
module flash_prog_ctrl_test;

    localparam int AW = 8;
    localparam int WC = 8;
    localparam int EC = 20;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    mode = 3'd0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic          strobe_n = 1'b1;
    logic          ready, err, ready_lv, err_lv;
    logic [7:0]    rdata, rdata_lv;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [7:0] exp_mem [DEPTH];

    always #4 clk = ~clk;

    flash_prog_ctrl #(.ADDR_W(AW), .WRITE_CYCLES(WC), .ERASE_CYCLES(EC), .LOW_VOLT(0)) uut (
        .clk(clk), .rst(rst), .mode_i(mode), .addr_i(addr), .wdata_i(wdata),
        .strobe_n_i(strobe_n), .ready_o(ready), .rdata_o(rdata), .err_o(err));

    flash_prog_ctrl #(.ADDR_W(AW), .WRITE_CYCLES(WC), .ERASE_CYCLES(EC), .LOW_VOLT(1)) uut_lv (
        .clk(clk), .rst(rst), .mode_i(mode), .addr_i(addr), .wdata_i(wdata),
        .strobe_n_i(strobe_n), .ready_o(ready_lv), .rdata_o(rdata_lv), .err_o(err_lv));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Read at the next falling edge, after the combinational path settles
    task automatic rd(input logic [2:0] m, input logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk);
        mode = m; addr = a;
        #1;
        v = rdata;
    endtask

    // Full program pulse; returns once the self-timed write has ended
    task automatic prog(input logic [2:0] m, input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        mode = m; addr = a; wdata = d; strobe_n = 1'b0;
        @(negedge clk);
        strobe_n = 1'b1;
        @(negedge clk);
        mode = 3'd0;
        repeat (WC) @(negedge clk);
    endtask

    task automatic erase_hold(input int n);
        @(negedge clk);
        mode = 3'd3; strobe_n = 1'b0;
        repeat (n) @(negedge clk);
        strobe_n = 1'b1;
        @(negedge clk);
        mode = 3'd0;
    endtask

    task automatic sweep(input string req);
        logic [7:0] v;
        for (int a = 0; a < DEPTH; a++) begin
            rd(3'd4, AW'(a), v);
            chk(req, v, exp_mem[a]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        chk("R9 ready after reset", {7'b0, ready}, 8'h01);
        chk("R9 err after reset", {7'b0, err}, 8'h00);

        // R1: full erase blanks everything
        erase_hold(EC);
        for (int a = 0; a < DEPTH; a++) exp_mem[a] = 8'hFF;
        sweep("R1 erase blank");

        // R2/R3: timing and polling with bit 7 set
        @(negedge clk);
        mode = 3'd1; addr = 8'h10; wdata = 8'hA5; strobe_n = 1'b0;
        @(negedge clk);
        strobe_n = 1'b1;
        @(negedge clk);
        mode = 3'd4; addr = 8'h10; #1;
        chk("R2 ready low after start", {7'b0, ready}, 8'h00);
        chk("R3 poll bit7 set", rdata, 8'h00);
        addr = 8'h11; #1;
        chk("R3 other addr during write", rdata, 8'hFF);
        repeat (WC - 1) @(negedge clk);
        addr = 8'h10; #1;
        chk("R2 ready low last busy cycle", {7'b0, ready}, 8'h00);
        chk("R3 poll still active", rdata, 8'h00);
        @(negedge clk); #1;
        chk("R2 ready back high", {7'b0, ready}, 8'h01);
        chk("R2 data after write", rdata, 8'hA5);
        exp_mem[8'h10] = 8'hA5;

        // R3: polling with bit 7 clear
        @(negedge clk);
        mode = 3'd1; addr = 8'h11; wdata = 8'h3C; strobe_n = 1'b0;
        @(negedge clk);
        strobe_n = 1'b1;
        @(negedge clk);
        mode = 3'd4; #1;
        chk("R3 poll bit7 clear", rdata, 8'h80);
        repeat (WC) @(negedge clk);
        exp_mem[8'h11] = 8'h3C;

        // R2/R4: two full passes, stored value is the AND
        for (int a = 0; a < DEPTH; a++) begin
            prog(3'd1, AW'(a), 8'(a) ^ 8'h5A);
            exp_mem[a] = exp_mem[a] & (8'(a) ^ 8'h5A);
        end
        sweep("R2 first pass");
        for (int a = 0; a < DEPTH; a++) begin
            prog(3'd1, AW'(a), ~8'(a * 3));
            exp_mem[a] = exp_mem[a] & ~8'(a * 3);
        end
        sweep("R4 and rule");

        // R8: pulse inside an ongoing write
        @(negedge clk);
        mode = 3'd1; addr = 8'h20; wdata = 8'h0F; strobe_n = 1'b0;
        @(negedge clk);
        strobe_n = 1'b1;
        @(negedge clk);
        addr = 8'h21; wdata = 8'h00; strobe_n = 1'b0;
        @(negedge clk);
        strobe_n = 1'b1;
        @(negedge clk); #1;
        chk("R8 err set", {7'b0, err}, 8'h01);
        repeat (WC - 3) @(negedge clk); #1;
        chk("R8 window not extended (busy)", {7'b0, ready}, 8'h00);
        @(negedge clk); #1;
        chk("R8 window not extended (ready)", {7'b0, ready}, 8'h01);
        exp_mem[8'h20] = exp_mem[8'h20] & 8'h0F;
        rd(3'd4, 8'h21, v);
        chk("R8 ignored write", v, exp_mem[8'h21]);
        rd(3'd4, 8'h20, v);
        chk("R8 first write kept", v, exp_mem[8'h20]);

        // R1: short hold does nothing
        erase_hold(EC - 1);
        sweep("R1 short hold");

        // R7/R10: identity and idle reads
        rd(3'd5, 8'h30, v); chk("R7 maker", v, 8'h1E);
        rd(3'd5, 8'h31, v); chk("R7 device", v, 8'h51);
        rd(3'd5, 8'h32, v); chk("R7 vpp high", v, 8'hFF);
        chk("R7 vpp low variant", rdata_lv, 8'h05);
        rd(3'd5, 8'h33, v); chk("R7 other", v, 8'hFF);
        rd(3'd0, 8'h20, v); chk("R10 idle read", v, 8'hFF);
        rd(3'd3, 8'h20, v); chk("R10 erase mode read", v, 8'hFF);
        rd(3'd6, 8'h20, v); chk("R10 mode 6 read", v, 8'hFF);
        @(negedge clk);
        mode = 3'd4; strobe_n = 1'b0;
        @(negedge clk);
        strobe_n = 1'b1;
        @(negedge clk); #1;
        chk("R10 verify pulse no start", {7'b0, ready}, 8'h01);

        // R5/R6: lock bits
        prog(3'd2, 8'h03, 8'h00);
        rd(3'd4, 8'h21, v); chk("R5 selector 3 no lock", v, exp_mem[8'h21]);
        prog(3'd2, 8'h02, 8'h00);
        rd(3'd4, 8'h21, v); chk("R6 lock3 still readable", v, exp_mem[8'h21]);
        @(negedge clk);
        mode = 3'd2; addr = 8'h00; strobe_n = 1'b0;
        @(negedge clk);
        strobe_n = 1'b1;
        @(negedge clk); #1;
        chk("R5 lock write busy", {7'b0, ready}, 8'h00);
        repeat (WC) @(negedge clk);
        rd(3'd4, 8'h21, v); chk("R6 lock1 hides", v, 8'hFF);
        rd(3'd4, 8'h10, v); chk("R6 lock1 hides 2", v, 8'hFF);
        rd(3'd5, 8'h30, v); chk("R7 ident under lock", v, 8'h1E);

        // R9: reset keeps locks, clears err
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        chk("R9 err cleared", {7'b0, err}, 8'h00);
        chk("R9 ready set", {7'b0, ready}, 8'h01);
        rd(3'd4, 8'h21, v); chk("R9 lock kept", v, 8'hFF);

        // R1: erase clears locks
        erase_hold(EC);
        prog(3'd1, 8'h21, 8'h12);
        rd(3'd4, 8'h21, v); chk("R1 locks cleared", v, 8'h12);
        rd(3'd4, 8'h10, v); chk("R1 erased byte", v, 8'hFF);
        prog(3'd2, 8'h01, 8'h00);
        rd(3'd4, 8'h21, v); chk("R6 lock2 hides", v, 8'hFF);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule